// File: doc/BRIEF.md
# Banked Data Memory with Access Window

This block holds the byte-wide data storage of a small 8-bit processor core and resolves every operand address the core presents into a 12-bit physical address. The store spans 000h to FFFh as sixteen banks of 256 bytes each. General-purpose bytes fill it from 000h upward. The special-function area sits at the top of the last bank.

A 4-bit bank register normally supplies the upper address bits, and the instruction supplies the 8-bit offset. When the instruction clears its window bit, the bank register is ignored. Offsets below 80h then land at the bottom of bank 0, and offsets from 80h up land at the top of bank 15, so common variables and control registers can be reached in a single cycle without first reloading the bank.

Register-to-register moves use a separate full-address mode. In that mode a complete 12-bit address bypasses both the bank register and the window. The resolved address is also driven out of the block so that the mapping can be observed directly.

Top module: `banked_dmem`

## Requirements
- R1: While reset is asserted and right after it, the bank register reads 0 and the read data output reads 00h.
- R2: With full mode low and the window bit at 1, the resolved address is the bank register value in bits 11:8 and the operand offset in bits 7:0.
- R3: With full mode low and the window bit at 0, offsets 00h to 7Fh resolve to 000h to 07Fh and offsets 80h to FFh resolve to F80h to FFFh, whatever the bank register holds.
- R4: With full mode high, the resolved address equals the 12-bit full address, and neither the bank register nor the window bit affects it.
- R5: A bank register write loads the new value at the clock edge. An access in the same cycle as the write still uses the old value, and the access in the following cycle uses the new one.
- R6: A write stores its byte at the resolved address. A read returns the byte at the resolved address on the read data output one clock edge after the read strobe is sampled.
- R7: When a read and a write hit the same address in the same cycle, the read returns the byte held before the write.
- R8: The read data output holds its value in every cycle in which no read is sampled.
- R9: Reset leaves the stored bytes unchanged.
- R10: A byte written through the window is the same storage as the byte at its physical address when that address is reached through the bank register or through full mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_addr | input | 8 | Operand offset from the instruction |
| win_n | input | 1 | 1: use the bank register, 0: use the fixed access window |
| full_mode | input | 1 | 1: use full_addr as given (register-to-register move) |
| full_addr | input | 12 | Full physical address for move instructions |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| bank_we | input | 1 | Bank register write strobe |
| bank_wdata | input | 4 | New bank register value |
| bank_q | output | 4 | Current bank register value |
| phys_addr | output | 12 | Resolved physical address (combinational) |
| rd_data | output | 8 | Registered read byte |

## Verification
The resolved address is combinational, so the bench checks it in the same half cycle in which the address inputs change. A bank write changes the resolved address only after the next rising edge, and the bench checks both the cycle of the write and the cycle after it. Read data is due one rising edge after the strobe is sampled, so it is compared at the next falling edge. It is also rechecked several cycles later with no strobe, to confirm that it holds. A collision of a read and a write is checked at that same falling edge against the previous content, and the new content is then read back one edge later.

// File: rtl/banked_dmem.sv
module banked_dmem #(
  parameter int BANK_W = 4,
  parameter int OFS_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OFS_W-1:0]          opnd_addr,
  input  logic                      win_n,
  input  logic                      full_mode,
  input  logic [BANK_W+OFS_W-1:0]   full_addr,
  input  logic                      rd_en,
  input  logic                      wr_en,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      bank_we,
  input  logic [BANK_W-1:0]         bank_wdata,
  output logic [BANK_W-1:0]         bank_q,
  output logic [BANK_W+OFS_W-1:0]   phys_addr,
  output logic [DATA_W-1:0]         rd_data
);
  localparam int ADDR_W = BANK_W + OFS_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [BANK_W-1:0] bank_r;
  logic [DATA_W-1:0] rd_r;
  logic [ADDR_W-1:0] banked_a, window_a;

  assign banked_a  = {bank_r, opnd_addr};
  assign window_a  = {{BANK_W{opnd_addr[OFS_W-1]}}, opnd_addr};
  assign phys_addr = full_mode ? full_addr : (win_n ? banked_a : window_a);
  assign bank_q    = bank_r;
  assign rd_data   = rd_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       bank_r <= '0;
    else if (bank_we) bank_r <= bank_wdata;

  always_ff @(posedge clk)
    if (wr_en) store[phys_addr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rd_r <= '0;
    else if (rd_en) rd_r <= store[phys_addr];

  // R1
  a_r1_reset_state: assert property (@(posedge clk) !rst_n |-> (bank_q == '0 && rd_data == '0));

  // R3
  a_r3_window_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_mode && !win_n && !opnd_addr[OFS_W-1]) |-> phys_addr[ADDR_W-1:OFS_W] == '0);
  a_r3_window_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_mode && !win_n && opnd_addr[OFS_W-1]) |-> phys_addr[ADDR_W-1:OFS_W] == '1);

  // R2
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !full_mode |-> phys_addr[OFS_W-1:0] == opnd_addr);

  // R4
  a_r4_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
    full_mode |-> phys_addr == full_addr);

  // R5
  a_r5_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> bank_q == $past(bank_wdata));
  a_r5_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we |=> $stable(bank_q));

  // R8
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/banked_dmem_test.sv
module banked_dmem_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  opnd_addr = '0;
  logic        win_n = 1'b1;
  logic        full_mode = 1'b0;
  logic [11:0] full_addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        bank_we = 1'b0;
  logic [3:0]  bank_wdata = '0;
  logic [3:0]  bank_q;
  logic [11:0] phys_addr;
  logic [7:0]  rd_data;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  banked_dmem uut (.clk, .rst_n, .opnd_addr, .win_n, .full_mode, .full_addr,
    .rd_en, .wr_en, .wr_data, .bank_we, .bank_wdata, .bank_q, .phys_addr, .rd_data);

  // {bank, win_n, offset, expected address}
  localparam logic [24:0] VEC [10] = '{
    {4'h3, 1'b1, 8'h45, 12'h345}, {4'hF, 1'b1, 8'h00, 12'hF00},
    {4'h0, 1'b1, 8'hFF, 12'h0FF}, {4'h7, 1'b0, 8'h12, 12'h012},
    {4'h7, 1'b0, 8'h7F, 12'h07F}, {4'h7, 1'b0, 8'h80, 12'hF80},
    {4'h2, 1'b0, 8'hFF, 12'hFFF}, {4'hA, 1'b1, 8'h80, 12'hA80},
    {4'h0, 1'b0, 8'h00, 12'h000}, {4'h5, 1'b1, 8'h7F, 12'h57F}};

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_bank(logic [3:0] b);
    @(negedge clk); bank_we = 1'b1; bank_wdata = b;
    @(negedge clk); bank_we = 1'b0;
  endtask

  task automatic do_write(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(string req, logic [7:0] exp);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check(req, {4'h0, rd_data}, {4'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 bank", {8'h0, bank_q}, 12'h0);
    check("R1 rd_data", {4'h0, rd_data}, 12'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 bank after release", {8'h0, bank_q}, 12'h0);

    // R2 / R3 mapping table
    for (int i = 0; i < 10; i++) begin
      set_bank(VEC[i][24:21]);
      win_n = VEC[i][20]; opnd_addr = VEC[i][19:12];
      #1 check(VEC[i][20] ? "R2 banked map" : "R3 window map", phys_addr, VEC[i][11:0]);
    end

    // R4 full mode ignores bank and window bit
    set_bank(4'h3);
    full_mode = 1'b1; full_addr = 12'hABC; win_n = 1'b0; opnd_addr = 8'h11;
    #1 check("R4 full win0", phys_addr, 12'hABC);
    win_n = 1'b1;
    #1 check("R4 full win1", phys_addr, 12'hABC);
    full_mode = 1'b0;

    // R5 bank write timing
    @(negedge clk); bank_we = 1'b1; bank_wdata = 4'h9; win_n = 1'b1; opnd_addr = 8'h10;
    #1 check("R5 same cycle old bank", phys_addr, 12'h310);
    @(negedge clk); bank_we = 1'b0;
    #1 check("R5 next cycle new bank", phys_addr, 12'h910);

    // R6 / R10 aliasing through window, bank and full mode
    win_n = 1'b0; opnd_addr = 8'h90;
    do_write(8'h5A);
    set_bank(4'hF); win_n = 1'b1;
    do_read("R10 window write read banked", 8'h5A);
    full_mode = 1'b1; full_addr = 12'h123;
    do_write(8'hC3);
    full_mode = 1'b0; set_bank(4'h1); opnd_addr = 8'h23;
    do_read("R6 full write read banked", 8'hC3);
    win_n = 1'b0; opnd_addr = 8'h23;
    do_write(8'h3C);
    full_mode = 1'b1; full_addr = 12'h023;
    do_read("R10 window low read full", 8'h3C);

    // R7 collision: old data returned
    full_addr = 12'h123;
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h11;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    check("R7 collision old data", {4'h0, rd_data}, 12'h0C3);
    do_read("R7 new data after", 8'h11);

    // R8 hold without read
    full_addr = 12'h023;
    repeat (3) @(negedge clk);
    check("R8 rd_data held", {4'h0, rd_data}, 12'h011);

    // R9 contents survive reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 rd_data in reset", {4'h0, rd_data}, 12'h0);
    check("R1 bank in reset", {8'h0, bank_q}, 12'h0);
    rst_n = 1'b1;
    full_addr = 12'h123;
    do_read("R9 kept across reset", 8'h11);
    full_addr = 12'hF90;
    do_read("R9 kept top bank", 8'h5A);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule